// File: doc/BRIEF.md
# UART Host Status and Interrupt Signaling

This block produces the status pins that one UART channel presents to its host processor. It watches the fill counts of the channel's 128-entry receive and transmit FIFOs and a small set of event flags from the rest of the channel. From these it drives two active-low ready pins that a DMA engine can watch, an interrupt request with a separate output enable, a 3-bit interrupt identification code, and a general-purpose user output.

The receive-ready pin has two rules, chosen by a DMA mode input. In mode 0 it announces a single waiting character. In mode 1 it waits until the receive fill reaches a programmed trigger level. One control bit has two jobs. It lets the interrupt pin leave high impedance, and it drives the user output to the opposite level.

Four interrupt sources are ranked in a fixed order: line error, receive data, transmit empty, then modem status. Line-error, modem and transmit-empty events are held until cleared. Receive data is a level condition taken from the receive fill.

Top module: `uart_hostsig`

## Requirements
- R1: `rx_trig_sel` picks the receive trigger level: 0 gives 1, 1 gives 32, 2 gives 64 and 3 gives 120 characters.
- R2: With `dma_mode` = 0, `rx_rdy_n` is 0 one cycle after `rx_count` is non-zero and 1 one cycle after it is zero.
- R3: With `dma_mode` = 1, `rx_rdy_n` is 1 one cycle after `rx_count` is below the trigger level, and 0 otherwise.
- R4: `tx_rdy_n` is 0 one cycle after `tx_count` is below 128, and 1 one cycle after `tx_count` equals 128.
- R5: `irq_oe` and `irq` are 1 only when, at the previous edge, `out2_ctl` was 1 and at least one enabled source was pending. In every other case `irq_oe` is 0, which means high impedance.
- R6: `out2_n` is the inverse of `out2_ctl`, with one cycle of delay.
- R7: The `irq_en` bits enable sources as follows: bit 0 receive data (`rx_count` at or above the trigger), bit 1 transmit empty, bit 2 line error, bit 3 modem status. Line-error and modem events stay pending until `line_clr` or `modem_clr` arrives. A set and a clear in the same cycle leave the source pending.
- R8: `int_id` reports the highest enabled pending source, one cycle after the cause. The codes are 3'b110 for line error, 3'b100 for receive data, 3'b010 for transmit empty, 3'b000 for modem status and 3'b001 when nothing is pending.
- R9: A pending transmit-empty source is cleared by `tx_write`, or by `id_read` while `int_id` shows 3'b010. A new `tx_empty_evt` in the same cycle overrides either clear.
- R10: A synchronous active-high `rst` clears every pending source. At the next edge it sets `rx_rdy_n`=1, `tx_rdy_n`=1, `irq`=0, `irq_oe`=0, `out2_n`=1 and `int_id`=3'b001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_count | input | 8 | Receive FIFO fill, 0 to 128 |
| tx_count | input | 8 | Transmit FIFO fill, 0 to 128 |
| rx_trig_sel | input | 2 | Receive trigger level select |
| dma_mode | input | 1 | 0: single-character ready rule, 1: trigger-level rule |
| irq_en | input | 4 | Interrupt source enables |
| out2_ctl | input | 1 | Interrupt output gate and user output control |
| line_err_evt | input | 1 | Receive line error event pulse |
| modem_evt | input | 1 | Modem status change event pulse |
| tx_empty_evt | input | 1 | Transmit holding buffer became empty |
| id_read | input | 1 | Host read of the identification code |
| tx_write | input | 1 | Host write into the transmit FIFO |
| line_clr | input | 1 | Host read of line status, clears line error |
| modem_clr | input | 1 | Host read of modem status, clears modem source |
| rx_rdy_n | output | 1 | Receive ready, active low |
| tx_rdy_n | output | 1 | Transmit ready, active low |
| irq | output | 1 | Interrupt request level |
| irq_oe | output | 1 | Interrupt pin output enable; 0 means high impedance |
| out2_n | output | 1 | User output, inverse of `out2_ctl` |
| int_id | output | 3 | Code of the highest pending source |

## Verification
The assertions assume that both fill counts stay between 0 and 128, and that every event and strobe input is a single-cycle pulse sampled at the clock edge. They also assume that reset is held high from time zero until the first edges have passed. The random stimulus draws fill counts only from 0 to 128, and it favours values around each trigger level and around the full mark. Event and clear pulses are kept rare so that pending sources last several cycles. Directed sequences then walk the priority ladder and both transmit-empty clear paths.

// File: rtl/uart_hostsig_pkg.sv
// Shared definitions for the UART host status block: identification codes,
// source ordering (index 0 = highest priority) and the trigger level picker.
package uart_hostsig_pkg;

    typedef enum logic [2:0] {
        IID_MODEM  = 3'b000,
        IID_NONE   = 3'b001,
        IID_THRE   = 3'b010,
        IID_RXDATA = 3'b100,
        IID_LINE   = 3'b110
    } iid_e;

    localparam int NSRC      = 4;
    localparam int SRC_LINE  = 0;
    localparam int SRC_RX    = 1;
    localparam int SRC_THRE  = 2;
    localparam int SRC_MODEM = 3;

    // Map a source index in priority order to its identification code.
    function automatic iid_e src_code(input int idx);
        case (idx)
            SRC_LINE:  return IID_LINE;
            SRC_RX:    return IID_RXDATA;
            SRC_THRE:  return IID_THRE;
            SRC_MODEM: return IID_MODEM;
            default:   return IID_NONE;
        endcase
    endfunction

    // Pick one of four trigger levels from the 2-bit select field.
    function automatic int unsigned trig_pick(input logic [1:0] sel,
                                              input int unsigned l0,
                                              input int unsigned l1,
                                              input int unsigned l2,
                                              input int unsigned l3);
        case (sel)
            2'd0:    return l0;
            2'd1:    return l1;
            2'd2:    return l2;
            default: return l3;
        endcase
    endfunction

endpackage

// File: rtl/uart_rdy_pins.sv
// Next-state logic for the two active-low ready pins.
// Assumes both counts lie in 0..DEPTH and trig is in 1..DEPTH.
module uart_rdy_pins #(
    parameter int DEPTH = 128,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    input  logic [CW-1:0] trig,
    input  logic          dma_mode,
    output logic          rx_rdy_n_d,
    output logic          tx_rdy_n_d
);

    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    // Receive ready: one waiting character in mode 0, trigger fill in mode 1.
    always_comb begin
        if (dma_mode) rx_rdy_n_d = (rx_count < trig);
        else          rx_rdy_n_d = (rx_count == '0);
    end

    // Transmit ready: deasserted only when no free location remains.
    always_comb begin
        tx_rdy_n_d = (tx_count >= FULL);
    end

endmodule

// File: rtl/uart_evt_latch.sv
// Bank of N sticky pending bits. Each bit sets on its event and clears on its
// clear strobe; a simultaneous set wins. Exposes both next and current state.
module uart_evt_latch #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_d,
    output logic [N-1:0] pend_q
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        // Next value of one pending bit, set taking precedence over clear.
        always_comb begin
            pend_d[g] = set_i[g] | (pend_q[g] & ~clr_i[g]);
        end

        // Hold the pending bit across cycles; reset clears it.
        always_ff @(posedge clk) begin
            if (rst) pend_q[g] <= 1'b0;
            else     pend_q[g] <= pend_d[g];
        end
    end

endmodule

// File: rtl/uart_irq_arb.sv
// Fixed-priority arbiter: request index 0 is the highest priority.
// Produces a one-hot grant and an any-request flag; purely combinational.
module uart_irq_arb #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);

    logic [N:0] blocked;

    assign blocked[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_pri
        // Grant a request only if no higher-priority request is active.
        always_comb begin
            gnt[g]         = req[g] & ~blocked[g];
            blocked[g + 1] = blocked[g] | req[g];
        end
    end

    // Flag that some request is active.
    always_comb begin
        any = blocked[N];
    end

endmodule

// File: rtl/uart_hostsig.sv
// Host-facing status outputs of one UART channel: ready pins, interrupt
// request with output enable, identification code and user output.
// All outputs are registered and reflect the inputs of the previous edge.
// Assumes fill counts stay within 0..DEPTH and strobes last one cycle.
module uart_hostsig
    import uart_hostsig_pkg::*;
#(
    parameter int DEPTH  = 128,
    parameter int TRIG_0 = 1,
    parameter int TRIG_1 = 32,
    parameter int TRIG_2 = 64,
    parameter int TRIG_3 = 120,
    parameter int CW     = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    input  logic [1:0]    rx_trig_sel,
    input  logic          dma_mode,
    input  logic [3:0]    irq_en,
    input  logic          out2_ctl,
    input  logic          line_err_evt,
    input  logic          modem_evt,
    input  logic          tx_empty_evt,
    input  logic          id_read,
    input  logic          tx_write,
    input  logic          line_clr,
    input  logic          modem_clr,
    output logic          rx_rdy_n,
    output logic          tx_rdy_n,
    output logic          irq,
    output logic          irq_oe,
    output logic          out2_n,
    output logic [2:0]    int_id
);

    localparam int NLAT = 3;   // latched sources: line, thre, modem
    localparam int L_LINE  = 0;
    localparam int L_THRE  = 1;
    localparam int L_MODEM = 2;

    logic [CW-1:0]   trig;
    logic            rx_rdy_n_d, tx_rdy_n_d;
    logic [NLAT-1:0] lat_set, lat_clr, lat_d, lat_q;
    logic [NSRC-1:0] req, gnt;
    logic [3:0]      en_by_src;
    logic            any_req;
    iid_e            id_d;
    iid_e            id_q;

    // Decode the trigger level from the select field.
    always_comb begin
        trig = CW'(trig_pick(rx_trig_sel, TRIG_0, TRIG_1, TRIG_2, TRIG_3));
    end

    uart_rdy_pins #(.DEPTH(DEPTH), .CW(CW)) u_rdy (
        .rx_count   (rx_count),
        .tx_count   (tx_count),
        .trig       (trig),
        .dma_mode   (dma_mode),
        .rx_rdy_n_d (rx_rdy_n_d),
        .tx_rdy_n_d (tx_rdy_n_d)
    );

    // Gather set and clear strobes for the sticky sources.
    always_comb begin
        lat_set[L_LINE]  = line_err_evt;
        lat_set[L_THRE]  = tx_empty_evt;
        lat_set[L_MODEM] = modem_evt;
        lat_clr[L_LINE]  = line_clr;
        lat_clr[L_THRE]  = tx_write | (id_read & (id_q == IID_THRE));
        lat_clr[L_MODEM] = modem_clr;
    end

    uart_evt_latch #(.N(NLAT)) u_lat (
        .clk    (clk),
        .rst    (rst),
        .set_i  (lat_set),
        .clr_i  (lat_clr),
        .pend_d (lat_d),
        .pend_q (lat_q)
    );

    // Reorder enable bits into priority order and mask the requests.
    always_comb begin
        en_by_src[SRC_LINE]  = irq_en[2];
        en_by_src[SRC_RX]    = irq_en[0];
        en_by_src[SRC_THRE]  = irq_en[1];
        en_by_src[SRC_MODEM] = irq_en[3];
        req[SRC_LINE]  = lat_d[L_LINE]  & en_by_src[SRC_LINE];
        req[SRC_RX]    = (rx_count >= trig) & en_by_src[SRC_RX];
        req[SRC_THRE]  = lat_d[L_THRE]  & en_by_src[SRC_THRE];
        req[SRC_MODEM] = lat_d[L_MODEM] & en_by_src[SRC_MODEM];
    end

    uart_irq_arb #(.N(NSRC)) u_arb (
        .req (req),
        .gnt (gnt),
        .any (any_req)
    );

    // Encode the one-hot grant into an identification code.
    always_comb begin
        id_d = IID_NONE;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (gnt[i]) id_d = src_code(i);
        end
    end

    // Register every host-facing output; reset drives the inactive levels.
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_rdy_n <= 1'b1;
            tx_rdy_n <= 1'b1;
            irq      <= 1'b0;
            irq_oe   <= 1'b0;
            out2_n   <= 1'b1;
            id_q     <= IID_NONE;
        end else begin
            rx_rdy_n <= rx_rdy_n_d;
            tx_rdy_n <= tx_rdy_n_d;
            irq      <= out2_ctl & any_req;
            irq_oe   <= out2_ctl & any_req;
            out2_n   <= ~out2_ctl;
            id_q     <= id_d;
        end
    end

    assign int_id = id_q;

endmodule

// File: rtl/uart_hostsig_chk.sv
// Property checker for uart_hostsig, attached with bind below.
// Assumes reset is high from time zero and counts stay within 0..DEPTH.
module uart_hostsig_chk
    import uart_hostsig_pkg::*;
#(
    parameter int DEPTH  = 128,
    parameter int TRIG_0 = 1,
    parameter int TRIG_1 = 32,
    parameter int TRIG_2 = 64,
    parameter int TRIG_3 = 120,
    parameter int CW     = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] tx_count,
    input logic [1:0]    rx_trig_sel,
    input logic          dma_mode,
    input logic [3:0]    irq_en,
    input logic          out2_ctl,
    input logic          line_err_evt,
    input logic          tx_empty_evt,
    input logic          tx_write,
    input logic          rx_rdy_n,
    input logic          tx_rdy_n,
    input logic          irq_oe,
    input logic          out2_n,
    input logic [2:0]    int_id
);

    logic rx_below;
    assign rx_below = (int'(rx_count) < int'(trig_pick(rx_trig_sel, TRIG_0, TRIG_1, TRIG_2, TRIG_3)));

    assert_rx_single_R2: assert property (@(posedge clk) disable iff (rst)
        !dma_mode |=> (rx_rdy_n == ($past(rx_count) == '0)));

    assert_rx_trigger_R3: assert property (@(posedge clk) disable iff (rst)
        dma_mode |=> (rx_rdy_n == $past(rx_below)));

    assert_tx_full_R4: assert property (@(posedge clk) disable iff (rst)
        (int'(tx_count) >= DEPTH) |=> tx_rdy_n);

    assert_tx_free_R4: assert property (@(posedge clk) disable iff (rst)
        (int'(tx_count) < DEPTH) |=> !tx_rdy_n);

    assert_irq_gate_R5: assert property (@(posedge clk) disable iff (rst)
        !out2_ctl |=> !irq_oe);

    assert_irq_noen_R5: assert property (@(posedge clk) disable iff (rst)
        (irq_en == 4'b0000) |=> !irq_oe);

    assert_user_low_R6: assert property (@(posedge clk) disable iff (rst)
        out2_ctl |=> !out2_n);

    assert_user_high_R6: assert property (@(posedge clk) disable iff (rst)
        !out2_ctl |=> out2_n);

    assert_line_first_R8: assert property (@(posedge clk) disable iff (rst)
        (line_err_evt && irq_en[2]) |=> (int_id == IID_LINE));

    assert_oe_has_id_R8: assert property (@(posedge clk) disable iff (rst)
        irq_oe |-> (int_id != IID_NONE));

    assert_thre_write_R9: assert property (@(posedge clk) disable iff (rst)
        (tx_write && !tx_empty_evt) |=> (int_id != IID_THRE));

    assert_reset_R10: assert property (@(posedge clk)
        rst |=> (rx_rdy_n && tx_rdy_n && !irq_oe && out2_n && int_id == IID_NONE));

endmodule

bind uart_hostsig uart_hostsig_chk #(
    .DEPTH(DEPTH), .TRIG_0(TRIG_0), .TRIG_1(TRIG_1),
    .TRIG_2(TRIG_2), .TRIG_3(TRIG_3), .CW(CW)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rx_count     (rx_count),
    .tx_count     (tx_count),
    .rx_trig_sel  (rx_trig_sel),
    .dma_mode     (dma_mode),
    .irq_en       (irq_en),
    .out2_ctl     (out2_ctl),
    .line_err_evt (line_err_evt),
    .tx_empty_evt (tx_empty_evt),
    .tx_write     (tx_write),
    .rx_rdy_n     (rx_rdy_n),
    .tx_rdy_n     (tx_rdy_n),
    .irq_oe       (irq_oe),
    .out2_n       (out2_n),
    .int_id       (int_id)
);

// File: tb/uart_hostsig_tb.sv
// Self-checking bench: seeded random stimulus plus directed corner cases,
// compared against a reference model written from the requirements.
module uart_hostsig_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] rx_count = '0, tx_count = '0;
    logic [1:0] rx_trig_sel = '0;
    logic       dma_mode = 1'b0, out2_ctl = 1'b0;
    logic [3:0] irq_en = '0;
    logic       line_err_evt = 0, modem_evt = 0, tx_empty_evt = 0;
    logic       id_read = 0, tx_write = 0, line_clr = 0, modem_clr = 0;
    logic       rx_rdy_n, tx_rdy_n, irq, irq_oe, out2_n;
    logic [2:0] int_id;

    int tests = 0;
    int fails = 0;

    // Reference state
    logic       m_le = 0, m_me = 0, m_te = 0;
    logic       e_rx = 1, e_tx = 1, e_irq = 0, e_oe = 0, e_o2 = 1;
    logic [2:0] e_id = 3'b001;

    always #4 clk = ~clk;   // 125 MHz

    uart_hostsig u_dut (
        .clk(clk), .rst(rst), .rx_count(rx_count), .tx_count(tx_count),
        .rx_trig_sel(rx_trig_sel), .dma_mode(dma_mode), .irq_en(irq_en),
        .out2_ctl(out2_ctl), .line_err_evt(line_err_evt), .modem_evt(modem_evt),
        .tx_empty_evt(tx_empty_evt), .id_read(id_read), .tx_write(tx_write),
        .line_clr(line_clr), .modem_clr(modem_clr), .rx_rdy_n(rx_rdy_n),
        .tx_rdy_n(tx_rdy_n), .irq(irq), .irq_oe(irq_oe), .out2_n(out2_n),
        .int_id(int_id)
    );

    function automatic int trig_of(input logic [1:0] s);
        int t;
        if (s == 2'd0)      t = 1;
        else if (s == 2'd1) t = 32;
        else if (s == 2'd2) t = 64;
        else                t = 120;
        return t;
    endfunction

    function automatic logic [2:0] id_of(input logic le, input logic rx, input logic te, input logic me);
        if (le) return 3'b110;
        if (rx) return 3'b100;
        if (te) return 3'b010;
        if (me) return 3'b000;
        return 3'b001;
    endfunction

    // Advance the reference model by one edge using the driven inputs.
    task automatic model_edge();
        int  t;
        logic nle, nme, nte, rxav, anyi;
        if (rst) begin
            m_le = 0; m_me = 0; m_te = 0;
            e_rx = 1; e_tx = 1; e_irq = 0; e_oe = 0; e_o2 = 1; e_id = 3'b001;
            return;
        end
        t    = trig_of(rx_trig_sel);
        rxav = (int'(rx_count) >= t);
        nle  = line_err_evt | (m_le & ~line_clr);
        nme  = modem_evt | (m_me & ~modem_clr);
        nte  = tx_empty_evt | (m_te & ~(tx_write | (id_read && e_id == 3'b010)));
        m_le = nle; m_me = nme; m_te = nte;
        e_id = id_of(nle & irq_en[2], rxav & irq_en[0], nte & irq_en[1], nme & irq_en[3]);
        anyi = (e_id != 3'b001);
        e_oe = out2_ctl & anyi;
        e_irq = e_oe;
        e_o2 = ~out2_ctl;
        e_rx = dma_mode ? (int'(rx_count) < t) : (rx_count == 0);
        e_tx = (int'(tx_count) >= 128);
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        string rq;
        rq = (tag != "") ? tag : (dma_mode ? "R3" : "R2");
        if (rst) rq = "R10";
        chk({7'b0, rx_rdy_n}, {7'b0, e_rx}, rq, "rx_rdy_n");
        chk({7'b0, tx_rdy_n}, {7'b0, e_tx}, (tag != "") ? tag : "R4", "tx_rdy_n");
        chk({7'b0, irq_oe}, {7'b0, e_oe}, (tag != "") ? tag : "R5", "irq_oe");
        chk({7'b0, irq}, {7'b0, e_irq}, (tag != "") ? tag : "R5", "irq");
        chk({7'b0, out2_n}, {7'b0, e_o2}, (tag != "") ? tag : "R6", "out2_n");
        chk({5'b0, int_id}, {5'b0, e_id}, (tag != "") ? tag : "R8", "int_id");
    endtask

    // One clock: inputs already driven at a falling edge.
    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
        line_err_evt = 0; modem_evt = 0; tx_empty_evt = 0;
        id_read = 0; tx_write = 0; line_clr = 0; modem_clr = 0;
    endtask

    function automatic logic [7:0] pick_count(input int t);
        int r;
        r = int'($urandom % 8);
        case (r)
            0: return 8'd0;
            1: return 8'd1;
            2: return 8'(t - 1);
            3: return 8'(t);
            4: return 8'd127;
            5: return 8'd128;
            default: return 8'($urandom % 129);
        endcase
    endfunction

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int unsigned sd;
        sd = $urandom(32'h5eed_2850);
        @(negedge clk);
        // R10: reset state
        rst = 1; out2_ctl = 1; irq_en = 4'hf; rx_count = 8'd50;
        step("R10"); step("R10");
        rst = 0;

        // R1: trigger boundaries for each select in mode 1
        dma_mode = 1; out2_ctl = 0; irq_en = 0;
        for (int s = 0; s < 4; s++) begin
            rx_trig_sel = 2'(s);
            rx_count = 8'(trig_of(2'(s)) - 1); step("R1");
            rx_count = 8'(trig_of(2'(s)));     step("R1");
        end
        // R2: single-character rule
        dma_mode = 0; rx_count = 0; step("R2");
        rx_count = 1; step("R2");
        // R4: full and one below
        tx_count = 127; step("R4");
        tx_count = 128; step("R4");
        tx_count = 0;

        // R9: transmit-empty clears
        rx_count = 0; out2_ctl = 1; irq_en = 4'b0010;
        tx_empty_evt = 1; step("R9");
        id_read = 1; step("R9");
        tx_empty_evt = 1; step("R9");
        tx_write = 1; step("R9");
        tx_empty_evt = 1; tx_write = 1; step("R9");
        tx_write = 1; step("R9");

        // R8 / R7: priority ladder
        irq_en = 4'hf; rx_trig_sel = 0;
        line_err_evt = 1; modem_evt = 1; tx_empty_evt = 1; rx_count = 5; step("R8");
        line_clr = 1; step("R8");
        rx_count = 0; step("R8");
        tx_write = 1; step("R8");
        step("R7");
        modem_clr = 1; modem_evt = 1; step("R7");
        modem_clr = 1; step("R7");
        // R7: disabled source does not raise irq
        irq_en = 4'b1011; line_err_evt = 1; step("R7");
        irq_en = 4'hf; step("R7");
        line_clr = 1; step("R7");

        // R5: gate closed with a pending source
        tx_empty_evt = 1; out2_ctl = 0; step("R5");
        out2_ctl = 1; step("R5");
        tx_write = 1; step("R5");

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            rx_trig_sel  = 2'($urandom % 4);
            dma_mode     = 1'($urandom % 2);
            rx_count     = pick_count(trig_of(rx_trig_sel));
            tx_count     = pick_count(128);
            irq_en       = 4'($urandom % 16);
            out2_ctl     = ($urandom % 4) != 0;
            line_err_evt = ($urandom % 16) == 0;
            modem_evt    = ($urandom % 16) == 0;
            tx_empty_evt = ($urandom % 8) == 0;
            id_read      = ($urandom % 6) == 0;
            tx_write     = ($urandom % 8) == 0;
            line_clr     = ($urandom % 10) == 0;
            modem_clr    = ($urandom % 10) == 0;
            rst          = ($urandom % 500) == 0;
            step("");
        end

        // R10: reset mid-run with sources pending
        rst = 0; irq_en = 4'hf; out2_ctl = 1;
        line_err_evt = 1; modem_evt = 1; step("R8");
        rst = 1; step("R10");
        rst = 0; rx_count = 0; step("R10");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule